// File: doc/BRIEF.md
# Masked Address Breakpoint Unit

This unit watches the processor's bus cycles and raises a debug interrupt when an access lands on an address that software has marked. It has seven independent channels. Each channel holds a 24-bit match address and a 24-bit don't-care mask. Each channel can be armed for instruction fetches, data reads and data writes in any combination. It can also be limited to user mode, to system mode, or allowed in both.

A data match becomes pending on the clock edge that samples the access. A fetch match is collected over the running instruction and is reported when the instruction-end strobe arrives. If the instruction that ends is a short one, flagged on the same cycle, the report moves to the end of the next instruction. Memory cycles and internal I/O cycles are compared the same way, because the bus carries no qualifier that tells them apart. DMA cycles are matched as plain reads and writes. The request to the core is held back while a DMA transfer is running or while the core already runs at the breakpoint's priority level 3.

Software reaches all state through a small register port. A control word can force any channel pending, which the debugger uses as a single-step request. The same control word holds a flag that tells the instruction decoder to run the trap-restart opcode as a no-operation. Pending bits are cleared by writing ones to the status word.

Top module: `bkpt_unit`

## Requirements
- R1: After reset, every register reads zero, no channel is pending, and irq_pend, irq_req and trap_suppress are low.
- R2: A channel matches when every address bit whose mask bit is 0 equals the match register; address bits whose mask bit is 1 are ignored.
- R3: bus_kind encodes 0 = fetch, 1 = data read, 2 = data write, 3 = no access. A channel's config bit 0 arms fetch, bit 1 arms read and bit 2 arms write, and an access of an unarmed kind never matches.
- R4: Config bit 3 allows matches when bus_sys is 0 (user mode), and config bit 4 allows matches when bus_sys is 1 (system mode).
- R5: A fetch match does not become pending before instr_end. It becomes pending on the edge where instr_end is high and instr_short is low, including a match on that same cycle.
- R6: When instr_end arrives with instr_short high, the fetch matches of that instruction stay unreported, and they become pending at the next instr_end.
- R7: Writing the control word (address 24) with bit c set, for c from 0 to 6, makes channel c pending on the next edge.
- R8: Writing the status word (address 25) clears each pending bit written as 1. Bits written as 0, and all other cycles, leave pending bits unchanged unless a new match sets them.
- R9: Control word bit 8 is stored, reads back, and drives trap_suppress.
- R10: irq_req is high only when some channel is pending, dma_active is low and cpu_prio is not 3. Pending bits are kept while the request is blocked.
- R11: A data read or write match, including a cycle during a DMA transfer, sets the channel's pending bit on the edge that samples it. irq_pend is the OR of all pending bits, and the status word reads them in bits 6:0.
- R12: Addresses 0-6 hold match registers, 8-14 hold masks, and 16-22 hold 5-bit configs, and all of them read back what was written. Addresses 7, 15, 23 and 26-31 read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_valid | input | 1 | A bus cycle is present this clock |
| bus_addr | input | 24 | Address of the bus cycle |
| bus_kind | input | 2 | Access kind (fetch, read, write, none) |
| bus_sys | input | 1 | 1 = system mode, 0 = user mode |
| instr_end | input | 1 | Last cycle of the current instruction |
| instr_short | input | 1 | The ending instruction is a short one |
| dma_active | input | 1 | A DMA transfer is in progress |
| cpu_prio | input | 2 | Current interrupt priority of the core |
| reg_addr | input | 5 | Register port address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 24 | Register write data |
| reg_rdata | output | 24 | Register read data (combinational) |
| irq_pend | output | 1 | Some channel is pending |
| irq_req | output | 1 | Level-3 breakpoint request to the core |
| trap_suppress | output | 1 | Decoder runs the trap-restart opcode as a no-operation |

## Verification
The assertions assume that bus_kind carries only its four defined codes. They also assume that register writes and bus cycles arrive as single-cycle levels sampled on the rising edge, and that the only ways to set a pending bit are a control-word write, a data match, or an instruction end. The random stimulus draws addresses close to the programmed match values, so that both hits and near-misses occur. It uses only the four bus_kind codes and keeps the forced-pending writes rare, so that pending bits drain through status clears and the hold and quiet properties are exercised while they are active.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

    localparam int REG_AW   = 5;
    localparam int CFG_W    = 5;
    localparam int SUPP_BIT = 8;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2,
        ACC_NONE  = 2'd3
    } acc_kind_e;

    typedef struct packed {
        logic sys_en;
        logic usr_en;
        logic wr_en;
        logic rd_en;
        logic fx_en;
    } chan_cfg_t;

    localparam logic [1:0] GRP_MATCH = 2'd0;
    localparam logic [1:0] GRP_MASK  = 2'd1;
    localparam logic [1:0] GRP_CFG   = 2'd2;
    localparam logic [1:0] GRP_CTL   = 2'd3;

    localparam logic [2:0] CTL_IDX_CTRL   = 3'd0;
    localparam logic [2:0] CTL_IDX_STATUS = 3'd1;

endpackage

// File: rtl/bkpt_chan_match.sv
module bkpt_chan_match
    import bkpt_pkg::*;
#(
    parameter int AW = 24
) (
    input  logic [AW-1:0] match_addr,
    input  logic [AW-1:0] mask_bits,
    input  chan_cfg_t     cfg,
    input  logic          bus_valid,
    input  logic [AW-1:0] bus_addr,
    input  acc_kind_e     kind,
    input  logic          sys_mode,
    output logic          fetch_hit,
    output logic          data_hit
);

    logic addr_eq;
    logic mode_ok;
    logic qual;

    always_comb begin
        addr_eq   = ((bus_addr ^ match_addr) & ~mask_bits) == '0;
        mode_ok   = sys_mode ? cfg.sys_en : cfg.usr_en;
        qual      = bus_valid & addr_eq & mode_ok;
        fetch_hit = qual & (kind == ACC_FETCH) & cfg.fx_en;
        data_hit  = qual & (((kind == ACC_READ) & cfg.rd_en) |
                            ((kind == ACC_WRITE) & cfg.wr_en));
    end

endmodule

// File: rtl/bkpt_exec_track.sv
module bkpt_exec_track #(
    parameter int NCH = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] fetch_hit,
    input  logic           instr_end,
    input  logic           instr_short,
    output logic [NCH-1:0] exec_fire
);

    typedef struct packed {
        logic [NCH-1:0] acc;
        logic [NCH-1:0] defer;
    } trk_t;

    trk_t t_d, t_q;
    logic [NCH-1:0] acc_now;

    always_comb begin
        t_d       = t_q;
        acc_now   = t_q.acc | fetch_hit;
        exec_fire = '0;
        if (instr_end) begin
            exec_fire = t_q.defer | (instr_short ? '0 : acc_now);
            t_d.acc   = '0;
            t_d.defer = instr_short ? acc_now : '0;
        end else begin
            t_d.acc   = acc_now;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

endmodule

// File: rtl/bkpt_unit.sv
module bkpt_unit
    import bkpt_pkg::*;
#(
    parameter int NCH = 7,
    parameter int AW  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic [AW-1:0]     bus_addr,
    input  logic [1:0]        bus_kind,
    input  logic              bus_sys,
    input  logic              instr_end,
    input  logic              instr_short,
    input  logic              dma_active,
    input  logic [1:0]        cpu_prio,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [AW-1:0]     reg_wdata,
    output logic [AW-1:0]     reg_rdata,
    output logic              irq_pend,
    output logic              irq_req,
    output logic              trap_suppress
);

    localparam logic [1:0] PRIO_BKPT = 2'd3;

    typedef struct packed {
        logic [NCH-1:0][AW-1:0] match;
        logic [NCH-1:0][AW-1:0] mask;
        chan_cfg_t [NCH-1:0]    cfg;
        logic [NCH-1:0]         pend;
        logic                   supp;
    } regs_t;

    regs_t s_d, s_q;

    acc_kind_e      kind;
    logic [NCH-1:0] fetch_hit;
    logic [NCH-1:0] data_hit;
    logic [NCH-1:0] exec_fire;
    logic [NCH-1:0] clr_bits;
    logic [NCH-1:0] frc_bits;
    logic [1:0]     grp;
    logic [2:0]     idx;
    logic           idx_ok;

    assign kind   = acc_kind_e'(bus_kind);
    assign grp    = reg_addr[4:3];
    assign idx    = reg_addr[2:0];
    assign idx_ok = int'(idx) < NCH;

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        bkpt_chan_match #(.AW(AW)) u_match (
            .match_addr (s_q.match[c]),
            .mask_bits  (s_q.mask[c]),
            .cfg        (s_q.cfg[c]),
            .bus_valid  (bus_valid),
            .bus_addr   (bus_addr),
            .kind       (kind),
            .sys_mode   (bus_sys),
            .fetch_hit  (fetch_hit[c]),
            .data_hit   (data_hit[c])
        );
    end

    bkpt_exec_track #(.NCH(NCH)) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .fetch_hit   (fetch_hit),
        .instr_end   (instr_end),
        .instr_short (instr_short),
        .exec_fire   (exec_fire)
    );

    always_comb begin
        s_d      = s_q;
        clr_bits = '0;
        frc_bits = '0;
        if (reg_we) begin
            unique case (grp)
                GRP_MATCH: if (idx_ok) s_d.match[idx] = reg_wdata;
                GRP_MASK:  if (idx_ok) s_d.mask[idx]  = reg_wdata;
                GRP_CFG:   if (idx_ok) s_d.cfg[idx]   = chan_cfg_t'(reg_wdata[CFG_W-1:0]);
                default: begin
                    if (idx == CTL_IDX_CTRL) begin
                        s_d.supp = reg_wdata[SUPP_BIT];
                        frc_bits = reg_wdata[NCH-1:0];
                    end else if (idx == CTL_IDX_STATUS) begin
                        clr_bits = reg_wdata[NCH-1:0];
                    end
                end
            endcase
        end
        s_d.pend = (s_q.pend & ~clr_bits) | frc_bits | data_hit | exec_fire;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        reg_rdata = '0;
        unique case (grp)
            GRP_MATCH: if (idx_ok) reg_rdata = s_q.match[idx];
            GRP_MASK:  if (idx_ok) reg_rdata = s_q.mask[idx];
            GRP_CFG:   if (idx_ok) reg_rdata[CFG_W-1:0] = s_q.cfg[idx];
            default: begin
                if (idx == CTL_IDX_CTRL)        reg_rdata[SUPP_BIT] = s_q.supp;
                else if (idx == CTL_IDX_STATUS) reg_rdata[NCH-1:0]  = s_q.pend;
            end
        endcase
    end

    assign irq_pend      = |s_q.pend;
    assign irq_req       = irq_pend & ~dma_active & (cpu_prio != PRIO_BKPT);
    assign trap_suppress = s_q.supp;

endmodule

// File: rtl/bkpt_unit_chk.sv
module bkpt_unit_chk
    import bkpt_pkg::*;
#(
    parameter int NCH = 7,
    parameter int AW  = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic [1:0]        bus_kind,
    input logic              instr_end,
    input logic              dma_active,
    input logic [1:0]        cpu_prio,
    input logic [REG_AW-1:0] reg_addr,
    input logic              reg_we,
    input logic [AW-1:0]     reg_wdata,
    input logic              irq_pend,
    input logic              irq_req,
    input logic              trap_suppress
);

    localparam logic [REG_AW-1:0] A_CTRL   = 5'd24;
    localparam logic [REG_AW-1:0] A_STATUS = 5'd25;

    logic data_cycle;
    assign data_cycle = bus_valid && (bus_kind == 2'd1 || bus_kind == 2'd2);

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!irq_pend && !trap_suppress));

    p_fetch_waits_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_pend && !instr_end && !reg_we && !data_cycle) |=> !irq_pend);

    p_force_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == A_CTRL && reg_wdata[NCH-1:0] != '0) |=> irq_pend);

    p_pend_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pend && !(reg_we && reg_addr == A_STATUS)) |=> irq_pend);

    p_supp_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == A_CTRL) |=> (trap_suppress == $past(reg_wdata[SUPP_BIT])));

    p_req_blocked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_active || cpu_prio == 2'd3 || !irq_pend) |-> !irq_req);

endmodule

bind bkpt_unit bkpt_unit_chk #(.NCH(NCH), .AW(AW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_valid     (bus_valid),
    .bus_kind      (bus_kind),
    .instr_end     (instr_end),
    .dma_active    (dma_active),
    .cpu_prio      (cpu_prio),
    .reg_addr      (reg_addr),
    .reg_we        (reg_we),
    .reg_wdata     (reg_wdata),
    .irq_pend      (irq_pend),
    .irq_req       (irq_req),
    .trap_suppress (trap_suppress)
);

// File: tb/bkpt_unit_test.sv
`timescale 1ns/100ps
module bkpt_unit_test;

    localparam int NCH = 7;
    localparam int AW  = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_valid = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [1:0]    bus_kind = 2'd3;
    logic          bus_sys = 1'b0;
    logic          instr_end = 1'b0;
    logic          instr_short = 1'b0;
    logic          dma_active = 1'b0;
    logic [1:0]    cpu_prio = 2'd0;
    logic [4:0]    reg_addr = 5'd0;
    logic          reg_we = 1'b0;
    logic [AW-1:0] reg_wdata = '0;
    logic [AW-1:0] reg_rdata;
    logic          irq_pend, irq_req, trap_suppress;

    bkpt_unit uut (.*);

    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    logic [AW-1:0]  m_match [NCH];
    logic [AW-1:0]  m_mask  [NCH];
    logic [4:0]     m_cfg   [NCH];
    logic [NCH-1:0] m_pend, m_acc, m_def;
    logic           m_supp;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic exp_hit(int c, logic fetch_side);
        logic eq, mode;
        eq   = ((bus_addr ^ m_match[c]) & ~m_mask[c]) == '0;
        mode = bus_sys ? m_cfg[c][4] : m_cfg[c][3];
        if (!(bus_valid && eq && mode)) return 1'b0;
        if (fetch_side) return bus_kind == 2'd0 && m_cfg[c][0];
        return (bus_kind == 2'd1 && m_cfg[c][1]) || (bus_kind == 2'd2 && m_cfg[c][2]);
    endfunction

    task automatic step();
        logic [NCH-1:0] fh, dh, clr, frc, accn, fire, np, na, nd;
        for (int c = 0; c < NCH; c++) begin
            fh[c] = exp_hit(c, 1'b1);
            dh[c] = exp_hit(c, 1'b0);
        end
        clr  = (reg_we && reg_addr == 5'd25) ? reg_wdata[NCH-1:0] : '0;
        frc  = (reg_we && reg_addr == 5'd24) ? reg_wdata[NCH-1:0] : '0;
        accn = m_acc | fh;
        fire = instr_end ? (m_def | (instr_short ? '0 : accn)) : '0;
        np   = (m_pend & ~clr) | frc | dh | fire;
        na   = instr_end ? '0 : accn;
        nd   = instr_end ? (instr_short ? accn : '0) : m_def;
        if (reg_we) begin
            if (reg_addr < 5'd7)                         m_match[reg_addr[2:0]] = reg_wdata;
            else if (reg_addr >= 5'd8 && reg_addr < 5'd15)  m_mask[reg_addr[2:0]] = reg_wdata;
            else if (reg_addr >= 5'd16 && reg_addr < 5'd23) m_cfg[reg_addr[2:0]] = reg_wdata[4:0];
            else if (reg_addr == 5'd24)                  m_supp = reg_wdata[8];
        end
        @(posedge clk);
        #1;
        m_pend = np; m_acc = na; m_def = nd;
    endtask

    task automatic wr(input logic [4:0] a, input logic [AW-1:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        step();
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [AW-1:0] d);
        reg_we = 1'b0; reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic bus(input logic v, input logic [AW-1:0] a, input logic [1:0] k,
                       input logic s, input logic e, input logic sh);
        bus_valid = v; bus_addr = a; bus_kind = k; bus_sys = s;
        instr_end = e; instr_short = sh;
        step();
        bus_valid = 1'b0; bus_kind = 2'd3; instr_end = 1'b0; instr_short = 1'b0;
    endtask

    task automatic chk_status(input string tag, input logic [NCH-1:0] exp);
        logic [AW-1:0] d;
        rd(5'd25, d);
        chk(tag, {8'h0, d}, {25'h0, exp});
    endtask

    initial begin
        logic [AW-1:0] d;
        void'($urandom(32'h5EED_B0C7));
        for (int c = 0; c < NCH; c++) begin
            m_match[c] = '0; m_mask[c] = '0; m_cfg[c] = '0;
        end
        m_pend = '0; m_acc = '0; m_def = '0; m_supp = 1'b0;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;

        // R1: reset state
        rd(5'd0, d);  chk("R1 match0", {8'h0, d}, 32'h0);
        rd(5'd8, d);  chk("R1 mask0", {8'h0, d}, 32'h0);
        rd(5'd16, d); chk("R1 cfg0", {8'h0, d}, 32'h0);
        rd(5'd24, d); chk("R1 ctrl", {8'h0, d}, 32'h0);
        chk_status("R1 status", '0);
        chk("R1 irq_pend", {31'h0, irq_pend}, 32'h0);
        chk("R1 irq_req", {31'h0, irq_req}, 32'h0);
        chk("R1 trap_suppress", {31'h0, trap_suppress}, 32'h0);

        // R12: register readback and unmapped slots
        wr(5'd0, 24'h123400); wr(5'd8, 24'h0000FF); wr(5'd16, 24'h00000A);
        rd(5'd0, d);  chk("R12 match0", {8'h0, d}, 32'h123400);
        rd(5'd8, d);  chk("R12 mask0", {8'h0, d}, 32'h0000FF);
        rd(5'd16, d); chk("R12 cfg0", {8'h0, d}, 32'h0000000A);
        wr(5'd7, 24'hABCDEF);
        rd(5'd7, d);  chk("R12 unmapped", {8'h0, d}, 32'h0);

        // R2 / R11: masked data read match
        bus(1, 24'h1234AB, 2'd1, 0, 0, 0);
        chk_status("R2 masked hit", 7'h01);
        wr(5'd25, 24'h1);
        chk_status("R8 w1c clear", 7'h00);
        bus(1, 24'h1235AB, 2'd1, 0, 0, 0);
        chk_status("R2 unmasked miss", 7'h00);

        // R3: access kinds
        bus(1, 24'h1234AB, 2'd2, 0, 0, 0);
        chk_status("R3 write unarmed", 7'h00);
        bus(1, 24'h1234AB, 2'd0, 0, 1, 0);
        chk_status("R3 fetch unarmed", 7'h00);

        // R4: modes
        bus(1, 24'h1234AB, 2'd1, 1, 0, 0);
        chk_status("R4 sys blocked", 7'h00);
        wr(5'd16, 24'h00001A);
        bus(1, 24'h1234AB, 2'd1, 1, 0, 0);
        chk_status("R4 sys allowed", 7'h01);
        wr(5'd25, 24'h1);

        // R5: fetch reported at instruction end
        wr(5'd1, 24'h400000); wr(5'd17, 24'h000011);
        bus(1, 24'h400000, 2'd0, 1, 0, 0);
        chk_status("R5 before end", 7'h00);
        bus(0, 24'h0, 2'd3, 1, 1, 0);
        chk_status("R5 at end", 7'h02);
        wr(5'd25, 24'h2);

        // R6: short-instruction deferral
        bus(1, 24'h400000, 2'd0, 1, 1, 1);
        chk_status("R6 short end", 7'h00);
        bus(0, 24'h0, 2'd3, 1, 0, 0);
        chk_status("R6 idle", 7'h00);
        bus(0, 24'h0, 2'd3, 1, 1, 0);
        chk_status("R6 next end", 7'h02);
        wr(5'd25, 24'h2);

        // R7: forced pending
        wr(5'd24, 24'h000004);
        chk_status("R7 force", 7'h04);
        rd(5'd24, d); chk("R7 ctrl readback", {8'h0, d}, 32'h0);
        wr(5'd25, 24'h0);
        chk_status("R8 write zero", 7'h04);

        // R10: request gating
        cpu_prio = 2'd3; #0.5;
        chk("R10 prio3 req", {31'h0, irq_req}, 32'h0);
        chk("R10 prio3 pend", {31'h0, irq_pend}, 32'h1);
        cpu_prio = 2'd2; #0.5;
        chk("R10 prio2 req", {31'h0, irq_req}, 32'h1);
        dma_active = 1'b1; #0.5;
        chk("R10 dma req", {31'h0, irq_req}, 32'h0);
        step();
        chk_status("R10 held", 7'h04);
        dma_active = 1'b0; #0.5;
        chk("R10 dma done", {31'h0, irq_req}, 32'h1);
        wr(5'd25, 24'h4);

        // R9: trap suppress
        wr(5'd24, 24'h000100);
        chk("R9 suppress on", {31'h0, trap_suppress}, 32'h1);
        rd(5'd24, d); chk("R9 ctrl read", {8'h0, d}, 32'h100);
        chk_status("R9 no force", 7'h00);
        wr(5'd24, 24'h0);
        chk("R9 suppress off", {31'h0, trap_suppress}, 32'h0);

        // R11: DMA cycle treated as data read
        dma_active = 1'b1;
        bus(1, 24'h123456, 2'd1, 0, 0, 0);
        chk_status("R11 dma hit", 7'h01);
        chk("R11 dma req held", {31'h0, irq_req}, 32'h0);
        dma_active = 1'b0; #0.5;
        chk("R11 req after dma", {31'h0, irq_req}, 32'h1);
        wr(5'd25, 24'h1);

        // random configuration
        for (int c = 0; c < NCH; c++) begin
            wr(5'(c), $urandom & 24'hFFFFFF);
            wr(5'(8 + c), $urandom & 24'h00000F);
            wr(5'(16 + c), $urandom & 24'h1F);
        end

        // random traffic
        for (int i = 0; i < 3000; i++) begin
            int r;
            int c;
            chk_status("R11 random status", m_pend);
            chk("R11 random irq_pend", {31'h0, irq_pend}, {31'h0, |m_pend});
            chk("R9 random suppress", {31'h0, trap_suppress}, {31'h0, m_supp});
            c = int'($urandom % NCH);
            bus_valid   = ($urandom % 4) != 0;
            bus_kind    = 2'($urandom);
            bus_addr    = m_match[c] ^ (($urandom % 3 == 0) ? 24'($urandom) : 24'($urandom & 24'h1F));
            bus_sys     = 1'($urandom);
            instr_end   = ($urandom % 3) == 0;
            instr_short = 1'($urandom);
            dma_active  = ($urandom % 8) == 0;
            cpu_prio    = 2'($urandom);
            r = int'($urandom % 32);
            reg_we = 1'b0;
            if (r < 4) begin
                reg_we = 1'b1; reg_addr = 5'd25; reg_wdata = 24'($urandom);
            end else if (r == 4) begin
                reg_we = 1'b1; reg_addr = 5'd24;
                reg_wdata = 24'($urandom & 24'h100) | (($urandom % 4 == 0) ? 24'($urandom & 24'h7F) : 24'h0);
            end
            #0.5;
            chk("R10 random irq_req", {31'h0, irq_req},
                {31'h0, (|m_pend) && !dma_active && cpu_prio != 2'd3});
            step();
            reg_we = 1'b0;
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_err++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule